// File: doc/BRIEF.md
# PHY Management Frame Engine

This block is a 32-bit control register that runs a complete clause-22 management transaction on an MDIO/MDC pair. The host writes one word that holds the opcode, the PHY address, the PHY register number and, for a write, the 16-bit value. The block then shifts out a serial frame and drives the management clock itself. Read data comes back into the low half of the same register.

When a frame finishes, the engine sets a ready flag. It can also raise a one-cycle interrupt pulse. The host polls the ready bit, or waits for the interrupt, and then reads the result from the register.

The frame is a 32-bit preamble of ones, then start code 01, the two-bit opcode, the five-bit PHY address, the five-bit register number, a two-bit turnaround and 16 data bits. All fields are sent most significant bit first. The MDC half period is a parameter counted in system clocks. Its default gives 2.5 MHz from a 200 MHz clock, so a frame takes 25.6 µs.

Top module: `mdio_mgmt_reg`

## Requirements
- R1: After reset the register reads 0x1000_0000 (ready set, all other bits zero), MDC is low, MDIO output enable is low and the interrupt output is low.
- R2: The register layout is data in bits 15:0, register number in bits 20:16, PHY address in bits 25:21, opcode in bits 27:26 (01 = write, 10 = read), ready in bit 28 and interrupt enable in bit 29. Bits 31:30 read as zero. An accepted write is read back with these fields unchanged apart from ready.
- R3: A write command (opcode 01) sends these 64 bits, each valid at the rising edge of MDC: 32 ones, 01, 01, the PHY address, the register number, 10, and the 16 data bits, all MSB first. The output enable stays high for all 64 bits.
- R4: A read command (opcode 10) sends 32 ones, 01, 10, the PHY address and the register number, and drives the output enable for those 46 bits only. MDIO is released for the 2 turnaround bits and the 16 data bits. The engine samples MDIO at each of the last 16 rising MDC edges, MSB first, and places the value in bits 15:0.
- R5: Accepting a valid command clears ready in the next cycle. Ready sets again when the frame completes, which takes at least 128 × HALF_DIV clock cycles and never more than 64 µs.
- R6: On completion the interrupt output pulses high for exactly one cycle, in the cycle ready rises, if bit 29 was set in the command. It stays low if bit 29 was clear.
- R7: MDC is low whenever the engine is idle. Each high phase of MDC lasts exactly HALF_DIV clock cycles. MDIO output and enable change only while MDC is low.
- R8: A register write while ready is clear has no effect: the register fields and the frame on the wire are unchanged.
- R9: A write with opcode 00 or 11 is stored in the register but starts no frame. Ready stays set, MDC stays low and no interrupt is raised.
- R10: After a write frame completes, bits 15:0 still hold the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| irq | output | 1 | One-cycle completion interrupt |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven to the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data from the PHY |

## Verification
The assertions check these rules on every cycle:
- MDC stays low while ready is set, and each MDC high phase lasts exactly HALF_DIV clocks.
- MDIO and its enable hold steady while MDC is high.
- The output enable is off for the turnaround and data of a read.
- Ready falls after each accepted command, and the interrupt is a single cycle aligned with ready.
- The upper fields hold still under writes made while busy.

The bench scenarios show what no single cycle can:
- the exact 64-bit sequence on the wire for writes and reads;
- the PHY value assembled MSB first into the register;
- the total frame time against the 64 µs limit;
- the interrupt enable taking effect;
- the handling of illegal opcodes.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int BIT_W      = 6;
  localparam logic [BIT_W-1:0] TA_BIT   = 6'd46;
  localparam logic [BIT_W-1:0] DATA_BIT = 6'd48;
  localparam logic [BIT_W-1:0] LAST_BIT = 6'd63;

  localparam int DATA_LSB  = 0;
  localparam int REG_LSB   = 16;
  localparam int PHY_LSB   = 21;
  localparam int OP_LSB    = 26;
  localparam int READY_BIT = 28;
  localparam int IE_BIT    = 29;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_BAD   = 2'b11
  } mdio_op_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          mdc_q, mdc_n;
  logic          tick;

  assign tick     = run && (cnt_q == CNT_LAST);
  assign rise_evt = tick && !mdc_q;
  assign fall_evt = tick &&  mdc_q;
  assign mdc      = mdc_q;

  always_comb begin
    cnt_n = cnt_q;
    mdc_n = mdc_q;
    if (!run) begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end else if (tick) begin
      cnt_n = '0;
      mdc_n = !mdc_q;
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  start_rd,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  rise_evt,
  input  logic                  fall_evt,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  busy,
  output logic                  done,
  output logic                  is_rd,
  output logic [BIT_W-1:0]      bit_idx,
  output logic [15:0]           rd_word
);
  logic [FRAME_BITS-1:0] shift_q, shift_n;
  logic [BIT_W-1:0]      cnt_q, cnt_n;
  logic                  busy_q, busy_n;
  logic                  rd_q, rd_n;
  logic                  done_q, done_n;
  logic [15:0]           word_q, word_n;

  always_comb begin
    shift_n = shift_q;
    cnt_n   = cnt_q;
    busy_n  = busy_q;
    rd_n    = rd_q;
    word_n  = word_q;
    done_n  = 1'b0;
    if (start) begin
      shift_n = frame;
      cnt_n   = '0;
      busy_n  = 1'b1;
      rd_n    = start_rd;
    end else if (busy_q) begin
      if (rise_evt && rd_q && (cnt_q >= DATA_BIT))
        word_n = {word_q[14:0], mdio_i};
      if (fall_evt) begin
        if (cnt_q == LAST_BIT) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end else begin
          cnt_n   = cnt_q + 6'd1;
          shift_n = {shift_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      shift_q <= shift_n;
      cnt_q   <= cnt_n;
      busy_q  <= busy_n;
      rd_q    <= rd_n;
      done_q  <= done_n;
      word_q  <= word_n;
    end
  end

  assign mdio_o  = shift_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && (!rd_q || (cnt_q < TA_BIT));
  assign busy    = busy_q;
  assign done    = done_q;
  assign is_rd   = rd_q;
  assign bit_idx = cnt_q;
  assign rd_word = word_q;
endmodule

// File: rtl/mdio_ctl_reg.sv
module mdio_ctl_reg
  import mdio_mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  input  logic                  done,
  input  logic [15:0]           rd_word,
  output logic                  start,
  output logic                  start_rd,
  output logic [FRAME_BITS-1:0] frame,
  output logic [31:0]           rd_data,
  output logic                  irq
);
  logic        ie_q, ie_n;
  logic        rdy_q, rdy_n;
  logic [1:0]  op_q, op_n;
  logic [4:0]  phy_q, phy_n;
  logic [4:0]  reg_q, reg_n;
  logic [15:0] dat_q, dat_n;
  logic        irq_q, irq_n;
  logic        accept, op_ok;
  logic [1:0]  wr_op;

  assign wr_op    = wr_data[OP_LSB +: 2];
  assign op_ok    = (wr_op == OP_WRITE) || (wr_op == OP_READ);
  assign accept   = wr_en && rdy_q;
  assign start    = accept && op_ok;
  assign start_rd = (wr_op == OP_READ);
  assign frame    = {32'hFFFF_FFFF, 2'b01, wr_op, wr_data[PHY_LSB +: 5],
                     wr_data[REG_LSB +: 5], 2'b10, wr_data[DATA_LSB +: 16]};

  always_comb begin
    ie_n  = ie_q;
    rdy_n = rdy_q;
    op_n  = op_q;
    phy_n = phy_q;
    reg_n = reg_q;
    dat_n = dat_q;
    irq_n = 1'b0;
    if (accept) begin
      ie_n  = wr_data[IE_BIT];
      op_n  = wr_op;
      phy_n = wr_data[PHY_LSB +: 5];
      reg_n = wr_data[REG_LSB +: 5];
      dat_n = wr_data[DATA_LSB +: 16];
      rdy_n = !op_ok;
    end else if (done) begin
      rdy_n = 1'b1;
      irq_n = ie_q;
      if (op_q == OP_READ) dat_n = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      rdy_q <= 1'b1;
      op_q  <= 2'b00;
      phy_q <= '0;
      reg_q <= '0;
      dat_q <= '0;
      irq_q <= 1'b0;
    end else begin
      ie_q  <= ie_n;
      rdy_q <= rdy_n;
      op_q  <= op_n;
      phy_q <= phy_n;
      reg_q <= reg_n;
      dat_q <= dat_n;
      irq_q <= irq_n;
    end
  end

  assign rd_data = {2'b00, ie_q, rdy_q, op_q, phy_q, reg_q, dat_q};
  assign irq     = irq_q;
endmodule

// File: rtl/mdio_mgmt_reg.sv
module mdio_mgmt_reg
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic                  seq_start, seq_start_rd, seq_busy, seq_done, seq_rd;
  logic [FRAME_BITS-1:0] seq_frame;
  logic [BIT_W-1:0]      seq_bit;
  logic [15:0]           seq_word;
  logic                  mdc_rise, mdc_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mdio_ctl_reg u_ctl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .done     (seq_done),
    .rd_word  (seq_word),
    .start    (seq_start),
    .start_rd (seq_start_rd),
    .frame    (seq_frame),
    .rd_data  (rd_data),
    .irq      (irq)
  );

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (seq_busy),
    .mdc      (mdc),
    .rise_evt (mdc_rise),
    .fall_evt (mdc_fall)
  );

  mdio_frame_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (seq_start),
    .start_rd (seq_start_rd),
    .frame    (seq_frame),
    .rise_evt (mdc_rise),
    .fall_evt (mdc_fall),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (seq_busy),
    .done     (seq_done),
    .is_rd    (seq_rd),
    .bit_idx  (seq_bit),
    .rd_word  (seq_word)
  );
endmodule

// File: rtl/mdio_mgmt_reg_chk.sv
module mdio_mgmt_reg_chk
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             irq,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             done,
  input logic             is_rd,
  input logic [BIT_W-1:0] bit_idx
);
  logic [15:0] hi_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_cnt_q <= '0;
    else if (mdc) hi_cnt_q <= hi_cnt_q + 16'd1;
    else          hi_cnt_q <= '0;
  end

  // R7
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[READY_BIT] |-> !mdc);

  // R7
  mdc_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_cnt_q == 16'(HALF_DIV)));

  // R7
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R4
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rd && (bit_idx >= TA_BIT)) |-> !mdio_oe);

  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data[READY_BIT] &&
     ((wr_data[OP_LSB +: 2] == OP_WRITE) || (wr_data[OP_LSB +: 2] == OP_READ)))
    |=> !rd_data[READY_BIT]);

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[READY_BIT] && !$past(rd_data[READY_BIT])));

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R8
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_data[READY_BIT] && !done) |=> $stable(rd_data[29:16]));
endmodule

bind mdio_mgmt_reg mdio_mgmt_reg_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .irq     (irq),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .busy    (seq_busy),
  .done    (seq_done),
  .is_rd   (seq_rd),
  .bit_idx (seq_bit)
);

// File: tb/mdio_mgmt_reg_test.sv
`timescale 1ns/1ps
module mdio_mgmt_reg_test;
  localparam int HALF = 40;
  localparam int LIMIT_CYC = 12800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  int nrise = 0;
  logic [63:0] cap = '0;
  logic [63:0] oecap = '0;
  logic        phy_drive = 1'b0;
  logic [15:0] phy_val = '0;
  realtime     t_rise = 0.0;
  realtime     t_hi = 0.0;
  int          cyc;

  always #2.5 clk = !clk;

  mdio_mgmt_reg #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    cap    = {cap[62:0], mdio_o};
    oecap  = {oecap[62:0], mdio_oe};
    nrise  = nrise + 1;
    t_rise = $realtime;
  end

  always @(negedge mdc) begin
    t_hi = $realtime - t_rise;
    if (phy_drive && nrise >= 48 && nrise <= 63) mdio_i = phy_val[63-nrise];
    else                                         mdio_i = 1'b1;
  end

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready();
    cyc = 0;
    while (!rd_data[28] && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic logic [31:0] mk(input logic ie, input logic [1:0] op,
                                     input logic [4:0] phy, input logic [4:0] rg,
                                     input logic [15:0] d);
    return {2'b00, ie, 1'b0, op, phy, rg, d};
  endfunction

  task automatic t_reset();
    check(rd_data == 32'h1000_0000, "R1 reset register", 64'(rd_data), 64'h1000_0000);
    check(!mdc && !mdio_oe && !irq, "R1 reset pins",
          {61'd0, mdc, mdio_oe, irq}, 64'd0);
  endtask

  task automatic t_write(input logic ie, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] d);
    logic [63:0] exp_f;
    exp_f = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
    nrise = 0;
    phy_drive = 1'b0;
    cmd(mk(ie, 2'b01, phy, rg, d));
    check(!rd_data[28], "R5 ready cleared", 64'(rd_data[28]), 64'd0);
    check(rd_data[29:16] == {ie, 1'b0, 2'b01, phy, rg}, "R2 fields readback",
          64'(rd_data[29:16]), 64'({ie, 1'b0, 2'b01, phy, rg}));
    wait_ready();
    check(cyc >= 128*HALF && cyc <= LIMIT_CYC, "R5 frame time",
          64'(cyc), 64'(128*HALF+1));
    check(irq == ie, "R6 irq at completion", 64'(irq), 64'(ie));
    check(cap == exp_f && nrise == 64, "R3 write frame bits", cap, exp_f);
    check(oecap == '1, "R3 write enable", oecap, '1);
    check(t_hi == HALF*5.0, "R7 mdc high phase", 64'(int'(t_hi)), 64'(HALF*5));
    check(rd_data == {2'b00, ie, 1'b1, 2'b01, phy, rg, d}, "R10 data kept",
          64'(rd_data), 64'({2'b00, ie, 1'b1, 2'b01, phy, rg, d}));
    @(negedge clk);
    check(!irq, "R6 irq one cycle", 64'(irq), 64'd0);
  endtask

  task automatic t_read(input logic ie, input logic [4:0] phy,
                        input logic [4:0] rg, input logic [15:0] v);
    logic [45:0] exp_h;
    exp_h = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg};
    nrise = 0;
    phy_val = v;
    phy_drive = 1'b1;
    cmd(mk(ie, 2'b10, phy, rg, 16'h0000));
    check(!rd_data[28], "R5 ready cleared read", 64'(rd_data[28]), 64'd0);
    wait_ready();
    phy_drive = 1'b0;
    check(cyc >= 128*HALF && cyc <= LIMIT_CYC, "R5 read frame time",
          64'(cyc), 64'(128*HALF+1));
    check(irq == ie, "R6 irq read", 64'(irq), 64'(ie));
    check(cap[63:18] == exp_h, "R4 read header", 64'(cap[63:18]), 64'(exp_h));
    check(oecap == {{46{1'b1}}, 18'd0}, "R4 read release", oecap,
          {{46{1'b1}}, 18'd0});
    check(rd_data == {2'b00, ie, 1'b1, 2'b10, phy, rg, v}, "R4 read data",
          64'(rd_data), 64'({2'b00, ie, 1'b1, 2'b10, phy, rg, v}));
    check(!mdc, "R7 mdc idle low", 64'(mdc), 64'd0);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] exp_f;
    exp_f = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd9, 2'b10, 16'h1234};
    nrise = 0;
    phy_drive = 1'b0;
    cmd(mk(1'b0, 2'b01, 5'd3, 5'd9, 16'h1234));
    repeat (300) @(negedge clk);
    cmd(mk(1'b1, 2'b10, 5'd30, 5'd1, 16'hFFFF));
    check(rd_data[29:0] == {1'b0, 1'b0, 2'b01, 5'd3, 5'd9, 16'h1234},
          "R8 write while busy ignored", 64'(rd_data),
          64'({1'b0, 1'b0, 2'b01, 5'd3, 5'd9, 16'h1234}));
    wait_ready();
    check(cap == exp_f && !irq, "R8 frame unchanged", cap, exp_f);
  endtask

  task automatic t_bad_op(input logic [1:0] op);
    nrise = 0;
    cmd(mk(1'b1, op, 5'd7, 5'd2, 16'hBEEF));
    check(rd_data == {2'b00, 1'b1, 1'b1, op, 5'd7, 5'd2, 16'hBEEF},
          "R9 bad opcode stored", 64'(rd_data),
          64'({2'b00, 1'b1, 1'b1, op, 5'd7, 5'd2, 16'hBEEF}));
    repeat (3*HALF) begin
      @(negedge clk);
      if (irq) n_bad++;
    end
    check(nrise == 0 && !mdc && !mdio_oe && !irq, "R9 no frame",
          64'(nrise), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write(1'b1, 5'd1, 5'd0, 16'hA5C3);
    t_write(1'b0, 5'd31, 5'd31, 16'h0001);
    t_read(1'b1, 5'd5, 5'd2, 16'h8421);
    t_read(1'b0, 5'd0, 5'd17, 16'h7FFE);
    t_busy_ignore();
    t_bad_op(2'b00);
    t_bad_op(2'b11);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule